// File: doc/BRIEF.md
# I2C Master Write Controller

This block is the transmit half of an I2C bus master, run by software through four byte-wide registers. Software enables the engine and places a slave address with the write bit (0) in the data register. It then requests a start. The engine drives a START condition and sends the address byte most significant bit first. After that it sends each byte that software queues in the data register, and it samples the slave's acknowledge in the ninth clock of every byte. It ends the transfer with a STOP condition when software asks for one.

The bus pins are open-drain. The block drives two enable outputs, where 1 pulls the line low, and it reads back the SDA line. One interrupt output combines two sources. The first is a transmit-ready source: the data register is empty and transmit interrupts are enabled. The second is a not-acknowledge source. The transmit-ready source returns after the first address bit has been sent, so software can queue the first data byte while the rest of the address is still going out. When the slave does not acknowledge, the engine parks SCL low. Software recovers by setting the stop request and clearing the transmit interrupt enable. The engine then discards any queued byte, sends STOP, and clears the stop request and the not-acknowledge flag by itself.

Each bit takes one slot of 4×QUARTER clock cycles. SCL is low for the first half of the slot and released for the second half.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset, both line enables are 0 and irq is 0. The register reads are: control = 0x00, status = 0x01 (empty only), link = 0x00.
- R2: Register map by reg_addr: 0 = data, 1 = control {txie[3], halt[2], go[1], en[0]}, 2 = status {nack[1], empty[0]} (read-only), 3 = link {ackv[1], ack[0]} (read-only). A write to address 0 stores the byte and clears empty.
- R3: No transfer starts while en is 0, even if go is set and the data register is full. Both lines stay released.
- R4: With en = 1, go = 1 and the data register full, the engine takes the byte and clears go. It drives SDA low while SCL is released, and this START is the only SDA fall while SCL is high.
- R5: Bits go out MSB first, one per slot, with SDA changing only while SCL is low. The exceptions are the START fall and the STOP rise.
- R6: empty stays 0 from the start request until the end of the first address bit slot. In the reading convention of the Verification section, it reads 1 again 2×SLOT+1 cycles after the go write.
- R7: irq = en AND ((txie AND empty) OR nack).
- R8: At the last cycle of the ninth slot of each byte, the engine samples SDA. It sets ackv to 1 and sets ack to 1 if SDA was low, 0 if it was high. A new start clears both.
- R9: If no acknowledge arrives, nack is set and SCL is held low until halt is set. The engine then discards the queued byte (empty = 1), sends STOP, releases both lines, and clears halt and nack.
- R10: If the data register is full when an acknowledged byte ends, the next byte follows with no gap: the ninth rising SCL edges of consecutive bytes are exactly 9×SLOT cycles apart, and empty returns to 1.
- R11: If an acknowledged byte ends with the data register empty and halt clear, SCL stays low and nothing is sent until software writes data or sets halt.
- R12: With halt set, an acknowledged byte is followed by STOP: SDA rises while SCL is released. Afterwards both lines are released and halt reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A register write takes effect at the edge that captures it. irq and the register reads follow combinationally, so they are checked at the next falling edge. A transfer launches one cycle after the go write. The bench counts falling edges from the write: empty must come back at edge 2×SLOT+1, and the spacing of acknowledge edges must be exactly 9×SLOT. The acknowledge outcome becomes visible only at the end of the ninth slot, so link and status checks wait for that slot to end, and hold checks start two slots after the slave saw the ninth rising edge. A bus-level slave model samples the lines at every falling clock edge. It decodes START, STOP and the data bits, drives the acknowledge, and records any illegal SDA change while SCL is high.

// File: rtl/i2c_wr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the I2C write master: sequencer states,
// register addresses and control bit positions.
package i2c_wr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_BITS, ST_ACK, ST_HOLD, ST_STOP
    } seq_state_t;

    localparam logic [1:0] RA_DATA = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_LINK = 2'd3;

    localparam int CB_EN   = 0;
    localparam int CB_GO   = 1;
    localparam int CB_HALT = 2;
    localparam int CB_TXIE = 3;
endpackage

// File: rtl/i2c_slot_timer.sv
`timescale 1ns/1ps
// Bit slot timer: counts 4*QUARTER cycles per slot while run is high.
// Assumes run drops between transfers, which restarts the slot at 0.
module i2c_slot_timer #(
    parameter int QUARTER = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic slot_end,
    output logic scl_high,
    output logic late
);
    localparam int SLOT = 4 * QUARTER;
    localparam int CW   = $clog2(SLOT);

    logic [CW-1:0] cyc;

    // Slot cycle counter, held at zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || slot_end) cyc <= '0;
        else                            cyc <= cyc + 1'b1;
    end

    assign slot_end = run && (cyc == CW'(SLOT - 1));
    assign scl_high = (cyc >= CW'(2 * QUARTER));
    assign late     = (cyc >= CW'(3 * QUARTER));
endmodule

// File: rtl/i2c_wr_regs.sv
`timescale 1ns/1ps
// Software register file: data byte, control bits, status and link flags.
// Assumes hardware events arrive as single-cycle pulses from the sequencer;
// a hardware clear of a control bit overrides a software write in the same cycle.
module i2c_wr_regs
    import i2c_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] waddr,
    input  logic [7:0] wdata,
    input  logic [1:0] raddr,
    output logic [7:0] rdata,
    input  logic       ev_launch,
    input  logic       ev_take,
    input  logic       ev_flush,
    input  logic       ev_ack_done,
    input  logic       ev_ack_low,
    input  logic       ev_stop_done,
    input  logic       hide_empty,
    output logic [7:0] data_q,
    output logic       full,
    output logic       en,
    output logic       go,
    output logic       halt,
    output logic       txie,
    output logic       nack,
    output logic       ack,
    output logic       ackv,
    output logic       tdre,
    output logic       irq
);
    // Data register and its occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full   <= 1'b0;
        end else if (wr && waddr == RA_DATA) begin
            data_q <= wdata;
            full   <= 1'b1;
        end else if (ev_take || ev_flush) begin
            full <= 1'b0;
        end
    end

    // Control bits with hardware self-clear of go and halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {txie, halt, go, en} <= 4'b0000;
        end else begin
            if (wr && waddr == RA_CTRL) begin
                en   <= wdata[CB_EN];
                go   <= wdata[CB_GO];
                halt <= wdata[CB_HALT];
                txie <= wdata[CB_TXIE];
            end
            if (ev_launch)    go   <= 1'b0;
            if (ev_stop_done) halt <= 1'b0;
        end
    end

    // Acknowledge and not-acknowledge flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nack <= 1'b0;
            ack  <= 1'b0;
            ackv <= 1'b0;
        end else begin
            if (ev_launch) begin
                ack  <= 1'b0;
                ackv <= 1'b0;
            end else if (ev_ack_done) begin
                ack  <= ev_ack_low;
                ackv <= 1'b1;
            end
            if (ev_ack_done && !ev_ack_low) nack <= 1'b1;
            else if (ev_stop_done)          nack <= 1'b0;
        end
    end

    assign tdre = !full && !hide_empty;
    assign irq  = en && ((txie && tdre) || nack);

    // Read multiplexer.
    always_comb begin
        unique case (raddr)
            RA_DATA: rdata = data_q;
            RA_CTRL: rdata = {4'b0000, txie, halt, go, en};
            RA_STAT: rdata = {6'b000000, nack, tdre};
            default: rdata = {6'b000000, ackv, ack};
        endcase
    end
endmodule

// File: rtl/i2c_wr_seq.sv
`timescale 1ns/1ps
// Bus sequencer: START, eight data bits MSB first, acknowledge slot,
// hold with SCL low, and STOP. Assumes no clock stretching or arbitration;
// SDA is synchronized through two flops before the acknowledge sample.
module i2c_wr_seq
    import i2c_wr_pkg::*;
#(
    parameter int QUARTER = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       go,
    input  logic       halt,
    input  logic       full,
    input  logic       nack,
    input  logic [7:0] data_q,
    input  logic       sda_in,
    output logic       ev_launch,
    output logic       ev_take,
    output logic       ev_flush,
    output logic       ev_ack_done,
    output logic       ev_ack_low,
    output logic       ev_stop_done,
    output logic       hide_empty,
    output logic       busy,
    output logic       scl_oe,
    output logic       sda_oe
);
    seq_state_t state, nxt;
    logic [7:0] shift;
    logic [2:0] bit_cnt;
    logic       first_byte;
    logic [1:0] sda_sync;
    logic       run, slot_end, scl_high, late, ack_end;

    assign run = (state == ST_START) || (state == ST_BITS) ||
                 (state == ST_ACK)   || (state == ST_STOP);

    i2c_slot_timer #(.QUARTER(QUARTER)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run),
        .slot_end(slot_end), .scl_high(scl_high), .late(late)
    );

    // Two-flop synchronizer for the SDA line.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_sync <= 2'b11;
        else        sda_sync <= {sda_sync[0], sda_in};
    end

    assign ack_end      = (state == ST_ACK) && slot_end;
    assign ev_ack_done  = ack_end;
    assign ev_ack_low   = !sda_sync[1];
    assign ev_launch    = (state == ST_IDLE) && en && go && full;
    assign ev_take      = ev_launch ||
                          (ack_end && ev_ack_low && !halt && full) ||
                          ((state == ST_HOLD) && !halt && full && !nack);
    assign ev_flush     = (ack_end && ev_ack_low && halt) ||
                          ((state == ST_HOLD) && halt);
    assign ev_stop_done = (state == ST_STOP) && slot_end;
    assign hide_empty   = (state == ST_START) ||
                          ((state == ST_BITS) && first_byte && bit_cnt == 3'd7);
    assign busy         = (state != ST_IDLE);

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (ev_launch) nxt = ST_START;
            ST_START: if (slot_end) nxt = ST_BITS;
            ST_BITS:  if (slot_end && bit_cnt == 3'd0) nxt = ST_ACK;
            ST_ACK: if (slot_end) begin
                if (!ev_ack_low) nxt = ST_HOLD;
                else if (halt)   nxt = ST_STOP;
                else if (full)   nxt = ST_BITS;
                else             nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (halt)               nxt = ST_STOP;
                else if (full && !nack) nxt = ST_BITS;
            end
            ST_STOP:  if (slot_end) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Shift register, bit counter and first-byte marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift      <= '0;
            bit_cnt    <= '0;
            first_byte <= 1'b0;
        end else begin
            if (ev_take) begin
                shift   <= data_q;
                bit_cnt <= 3'd7;
            end else if (state == ST_BITS && slot_end) begin
                shift   <= {shift[6:0], 1'b0};
                bit_cnt <= bit_cnt - 1'b1;
            end
            if (ev_launch)                         first_byte <= 1'b1;
            else if (state == ST_BITS && slot_end) first_byte <= 1'b0;
        end
    end

    // Open-drain line enables from state and slot phase.
    always_comb begin
        unique case (state)
            ST_START: begin scl_oe = 1'b0;      sda_oe = scl_high;  end
            ST_BITS:  begin scl_oe = !scl_high; sda_oe = !shift[7]; end
            ST_ACK:   begin scl_oe = !scl_high; sda_oe = 1'b0;      end
            ST_HOLD:  begin scl_oe = 1'b1;      sda_oe = 1'b0;      end
            ST_STOP:  begin scl_oe = !scl_high; sda_oe = !late;     end
            default:  begin scl_oe = 1'b0;      sda_oe = 1'b0;      end
        endcase
    end
endmodule

// File: rtl/i2c_wr_master.sv
`timescale 1ns/1ps
// I2C master write controller top: register file plus bus sequencer.
// Assumes a single master on the bus and sda_in carrying the wired-AND line level.
module i2c_wr_master #(
    parameter int QUARTER = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic [1:0] reg_raddr,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    logic       ev_launch, ev_take, ev_flush, ev_ack_done, ev_ack_low, ev_stop_done;
    logic       hide_empty, busy;
    logic [7:0] data_q;
    logic       full, en, go, halt, txie, nack, ack, ackv, tdre;

    i2c_wr_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr), .waddr(reg_addr), .wdata(reg_wdata),
        .raddr(reg_raddr), .rdata(reg_rdata),
        .ev_launch(ev_launch), .ev_take(ev_take), .ev_flush(ev_flush),
        .ev_ack_done(ev_ack_done), .ev_ack_low(ev_ack_low),
        .ev_stop_done(ev_stop_done), .hide_empty(hide_empty),
        .data_q(data_q), .full(full), .en(en), .go(go), .halt(halt),
        .txie(txie), .nack(nack), .ack(ack), .ackv(ackv), .tdre(tdre), .irq(irq)
    );

    i2c_wr_seq #(.QUARTER(QUARTER)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .en(en), .go(go), .halt(halt), .full(full), .nack(nack),
        .data_q(data_q), .sda_in(sda_in),
        .ev_launch(ev_launch), .ev_take(ev_take), .ev_flush(ev_flush),
        .ev_ack_done(ev_ack_done), .ev_ack_low(ev_ack_low),
        .ev_stop_done(ev_stop_done), .hide_empty(hide_empty), .busy(busy),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );
endmodule

// File: rtl/i2c_wr_checker.sv
`timescale 1ns/1ps
// Protocol checker for the I2C write master, bound to the top module.
// Relates register flags, sequencer activity and the line enables.
module i2c_wr_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic en,
    input logic full,
    input logic tdre,
    input logic nack,
    input logic halt,
    input logic ack,
    input logic ackv,
    input logic irq,
    input logic scl_oe,
    input logic sda_oe
);
    assert_launch_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(en) && $past(full)));

    assert_addr_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tdre);

    assert_nack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nack && !halt) |-> scl_oe);

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nack) |-> (!scl_oe && !sda_oe && !halt));

    assert_ack_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ackv);

    assert_irq_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && nack) |-> irq);
endmodule

bind i2c_wr_master i2c_wr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .en(en), .full(full),
    .tdre(tdre), .nack(nack), .halt(halt), .ack(ack), .ackv(ackv),
    .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_wr_master_bench.sv
`timescale 1ns/1ps
// Bench: register-level stimulus plus a behavioural bus slave that decodes
// START/STOP/bytes and checks the SDA-versus-SCL rule at every falling edge.
module i2c_wr_master_bench;
    localparam int QUARTER = 4;
    localparam int SLOT    = 4 * QUARTER;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] reg_raddr = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe, sda_in;

    int total = 0;
    int bad = 0;
    int cyc_n = 0;
    bit done = 0;

    // Slave model state
    logic slv_drive = 1'b0;
    bit   ack_en = 1'b1;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int   bitcnt = 0;
    logic [7:0] sh = '0;
    logic [7:0] rx_q[$];
    int   rx_t[$];
    int   starts = 0, stops = 0, glitches = 0;

    assign sda_in = !(sda_oe || slv_drive);

    i2c_wr_master #(.QUARTER(QUARTER)) u_i2c_wr_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    // Behavioural slave: decodes the bus at every falling clock edge.
    always @(negedge clk) begin
        logic scl, sda;
        scl = !scl_oe;
        sda = sda_in;
        if (rst_n) begin
            if (prev_scl && scl && prev_sda && !sda) begin
                starts++; bitcnt = 0;
            end else if (prev_scl && scl && !prev_sda && sda) begin
                stops++;
            end else if (prev_scl && scl && prev_sda != sda) begin
                glitches++;
            end
            if (!prev_scl && scl) begin
                if (bitcnt < 8) begin sh = {sh[6:0], sda}; bitcnt++; end
                else begin bitcnt = 0; rx_q.push_back(sh); rx_t.push_back(cyc_n); end
            end
            if (prev_scl && !scl) slv_drive = (bitcnt == 8) && ack_en;
        end
        prev_scl = scl;
        prev_sda = sda;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_tdre(output int n);
        logic [7:0] s;
        n = 0;
        rd(2'd2, s);
        while (!s[0] && n < 20000) begin
            @(negedge clk); n++; rd(2'd2, s);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n, g, hold_bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 irq", irq, 0);
        rd(2'd1, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd2, v); chk("R1 status", v, 8'h01);
        rd(2'd3, v); chk("R1 link", v, 8'h00);

        // R7: txie without en gives no irq
        reg_write(2'd1, 8'h08);
        chk("R7 irq gated by en", irq, 0);
        // R2: data write fills register
        reg_write(2'd0, 8'hA4);
        rd(2'd0, v); chk("R2 data readback", v, 8'hA4);
        rd(2'd2, v); chk("R2 empty cleared", v, 8'h00);
        // R3: go without en does nothing
        reg_write(2'd1, 8'h0A);
        hold_bad = 0;
        for (int i = 0; i < 5 * SLOT; i++) begin
            @(negedge clk);
            if (scl_oe || sda_oe) hold_bad++;
        end
        chk("R3 lines released", hold_bad, 0);
        chk("R3 no start", starts, 0);

        // Transaction A: acknowledged bytes
        ack_en = 1'b1;
        reg_write(2'd1, 8'h09);
        chk("R7 irq low while full", irq, 0);
        reg_write(2'd1, 8'h0B);
        wait_tdre(n);
        chk("R6 empty return cycle", n, 2 * SLOT + 1);
        chk("R4 start seen", starts, 1);
        rd(2'd1, v); chk("R4 go cleared", v, 8'h09);
        chk("R7 irq on empty", irq, 1);
        reg_write(2'd0, 8'h3C);
        chk("R7 irq drops after write", irq, 0);
        wait_tdre(n);
        g = 0;
        while (rx_q.size() < 2 && g < 20000) begin @(negedge clk); g++; end
        chk("R5 address byte", rx_q[0], 8'hA4);
        chk("R5 data byte", rx_q[1], 8'h3C);
        chk("R10 back-to-back spacing", rx_t[1] - rx_t[0], 9 * SLOT);
        repeat (2 * SLOT) @(negedge clk);
        rd(2'd3, v); chk("R8 link ack", v, 8'h03);
        hold_bad = 0;
        for (int i = 0; i < 6 * SLOT; i++) begin
            @(negedge clk);
            if (!scl_oe) hold_bad++;
        end
        chk("R11 scl held low", hold_bad, 0);
        chk("R11 nothing sent", rx_q.size(), 2);
        reg_write(2'd0, 8'hF0);
        wait_tdre(n);
        reg_write(2'd1, 8'h0D);
        g = 0;
        while (stops < 1 && g < 20000) begin @(negedge clk); g++; end
        repeat (SLOT) @(negedge clk);
        chk("R11 resumed byte", rx_q.size() > 2 ? rx_q[2] : 0, 8'hF0);
        chk("R12 stop count", stops, 1);
        chk("R12 scl released", scl_oe, 0);
        chk("R12 sda released", sda_oe, 0);
        rd(2'd1, v); chk("R12 halt cleared", v, 8'h09);

        // Transaction B: address not acknowledged
        ack_en = 1'b0;
        reg_write(2'd0, 8'h90);
        reg_write(2'd1, 8'h0B);
        wait_tdre(n);
        reg_write(2'd0, 8'h55);
        g = 0;
        rd(2'd2, v);
        while (!v[1] && g < 20000) begin @(negedge clk); g++; rd(2'd2, v); end
        chk("R9 status nack, full", v, 8'h02);
        rd(2'd3, v); chk("R8 link nack", v, 8'h02);
        chk("R7 irq on nack", irq, 1);
        hold_bad = 0;
        for (int i = 0; i < 4 * SLOT; i++) begin
            @(negedge clk);
            if (!scl_oe) hold_bad++;
        end
        chk("R9 scl parked", hold_bad, 0);
        reg_write(2'd1, 8'h05);
        g = 0;
        while (stops < 2 && g < 20000) begin @(negedge clk); g++; end
        repeat (4 * SLOT) @(negedge clk);
        rd(2'd2, v); chk("R9 flushed, nack cleared", v, 8'h01);
        rd(2'd1, v); chk("R9 halt cleared", v, 8'h01);
        chk("R9 irq low", irq, 0);
        chk("R9 lines released", {scl_oe, sda_oe}, 0);
        chk("R9 only address sent", rx_q.size(), 4);
        chk("R9 address byte", rx_q.size() > 3 ? rx_q[3] : 0, 8'h90);
        chk("R4 start count", starts, 2);
        chk("R5 no sda change with scl high", glitches, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule